// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block holds four independent down-counters behind a small word-addressed register bus with one interrupt line. Channels 0 and 1 count in 24 bits; channels 2 and 3 count in 32 bits. Each channel has a reload register and a live count register. It has an enable bit and a mode bit in a shared control word. While a channel is enabled its count falls by one every clock. When the count steps from one to zero, the channel raises its pending flag.

In periodic mode, a channel that sits at zero while enabled copies its reload value into the count on the next clock. This gives a repeating event every reload+1 cycles. In one-shot mode the channel parks at zero until software writes a new count. The pending flags share a register with the per-channel interrupt enables. Pending bits are cleared by writing ones to them, so writing back a value just read acknowledges everything it showed. The interrupt output is the registered OR of pending flags whose enables are set.

Top module: `quad_dtimer`

## Requirements
- R1: After a synchronous reset every register reads as zero, all channels are disabled, and `irq` is low.
- R2: The control word (byte address 0x0) holds channel t's enable at bit 2t and its mode at bit 2t+1, where 1 means periodic and 0 means one-shot. Bits 8+t hold a source-select flag that is stored and read back but changes no counting. All other control bits read as zero.
- R3: An enabled channel with a nonzero count decrements by exactly one per clock. A disabled channel holds its count.
- R4: When an enabled channel's count steps from 1 to 0, bit 4+t of the interrupt word (byte address 0x4) becomes 1 at the same clock edge.
- R5: An enabled periodic channel whose count is zero loads its reload value (byte address 0x10+4t) on the next clock, and it raises no new pending flag for that load.
- R6: An enabled one-shot channel whose count is zero stays at zero and raises no further pending flag.
- R7: The count register (byte address 0x20+4t) can be written at any time, independently of the reload register. A count write takes precedence over that cycle's decrement or reload.
- R8: In the interrupt word, bits 0..3 are interrupt enables that are written directly. Writing 1 to bit 4+t clears pending flag t, and writing 0 there leaves it unchanged. A flag set in the same cycle as its clear stays set.
- R9: `irq` equals, one clock later, the OR over channels of (pending AND interrupt enable).
- R10: On channels 0 and 1, bits 31..24 of the reload and count registers ignore writes and read as zero.
- R11: `bus_rdata` is registered: after each clock edge it shows the register addressed at that edge as it stood before the edge. Unmapped or non-word-aligned addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W (6) | Byte address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data for the address presented |
| irq | output | 1 | Registered combined interrupt |

## Verification
The per-channel assertions assume that a count write is signalled only by `bus_wr` together with that channel's exact, aligned count address. They also assume that the control word is the only source of enable and mode. The stimulus keeps to this by driving every access as a single aligned word write or read, changed at the falling edge. It never touches the control word and a count register in the same cycle without the reference model seeing it. The periodic-reload check compares against the reload value from the previous cycle. Reload writes to a running periodic channel are therefore made only while its count is nonzero, or they are accepted with the older value, and the model follows the same rule.

// File: rtl/qdt_pkg.sv
package qdt_pkg;
  // Word indices (byte address >> 2) of the register groups
  localparam int CTRL_WORD   = 0;
  localparam int IRQ_WORD    = 1;
  localparam int RELOAD_WORD = 4;
  localparam int COUNT_WORD  = 8;
  // Bit placement inside the control and interrupt words
  localparam int SRC_LSB     = 8;
  localparam int PEND_LSB    = 4;

  typedef enum logic {
    MODE_ONESHOT  = 1'b0,
    MODE_PERIODIC = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/qdt_channel.sv
module qdt_channel
  import qdt_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  cnt_mode_e         mode,
  input  logic              wr_reload,
  input  logic              wr_count,
  input  logic [CNT_W-1:0]  wdata,
  output logic [DATA_W-1:0] count_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] rld_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  // Step from one to zero, unless software overwrites the count this cycle
  assign hit_o   = en && !wr_count && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (wr_reload) rld_q <= wdata;
      if (wr_count) begin
        cnt_q <= wdata;
      end else if (en) begin
        if (!at_zero)                    cnt_q <= cnt_q - CNT_W'(1);
        else if (mode == MODE_PERIODIC)  cnt_q <= rld_q;
      end
    end
  end

  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign count_o  = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
      assign reload_o = {{(DATA_W-CNT_W){1'b0}}, rld_q};
    end else begin : g_full
      assign count_o  = cnt_q;
      assign reload_o = rld_q;
    end
  endgenerate
endmodule

// File: rtl/qdt_irq_ctrl.sv
module qdt_irq_ctrl #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [NUM_CH-1:0] ie_wdata,
  input  logic [NUM_CH-1:0] clr_wdata,
  input  logic [NUM_CH-1:0] hit,
  output logic [NUM_CH-1:0] ie_o,
  output logic [NUM_CH-1:0] pend_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] ie_q;
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] clr;
  logic              irq_q;

  assign clr = wr ? clr_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q   <= '0;
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr) ie_q <= ie_wdata;
      pend_q <= (pend_q & ~clr) | hit;
      irq_q  <= |(pend_q & ie_q);
    end
  end

  assign ie_o   = ie_q;
  assign pend_o = pend_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/quad_dtimer.sv
module quad_dtimer
  import qdt_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NARROW_CH = 2,
  parameter int NARROW_W  = 24,
  parameter int WIDE_W    = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int CTL_W  = 2 * NUM_CH;

  logic              aligned;
  logic [WORD_W-1:0] word;
  logic              wr_ctrl;
  logic              wr_irq;

  logic [CTL_W-1:0]  ctl_q;
  logic [NUM_CH-1:0] src_q;
  logic [NUM_CH-1:0] wr_rld;
  logic [NUM_CH-1:0] wr_cnt;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] ie;
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0][DATA_W-1:0] cnt_pk;
  logic [NUM_CH-1:0][DATA_W-1:0] rld_pk;

  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rdata_q;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign word    = bus_addr[ADDR_W-1:2];
  assign wr_ctrl = bus_wr && aligned && (word == WORD_W'(CTRL_WORD));
  assign wr_irq  = bus_wr && aligned && (word == WORD_W'(IRQ_WORD));

  // Control word: interleaved enable/mode pairs plus stored source flags
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      src_q <= '0;
    end else if (wr_ctrl) begin
      ctl_q <= bus_wdata[CTL_W-1:0];
      src_q <= bus_wdata[SRC_LSB +: NUM_CH];
    end
  end

  generate
    for (genvar t = 0; t < NUM_CH; t++) begin : g_ch
      localparam int CW = (t < NARROW_CH) ? NARROW_W : WIDE_W;

      assign wr_rld[t] = bus_wr && aligned && (word == WORD_W'(RELOAD_WORD + t));
      assign wr_cnt[t] = bus_wr && aligned && (word == WORD_W'(COUNT_WORD + t));

      qdt_channel #(
        .CNT_W  (CW),
        .DATA_W (DATA_W)
      ) u_chan (
        .clk       (clk),
        .rst       (rst),
        .en        (ctl_q[2*t]),
        .mode      (cnt_mode_e'(ctl_q[2*t+1])),
        .wr_reload (wr_rld[t]),
        .wr_count  (wr_cnt[t]),
        .wdata     (bus_wdata[CW-1:0]),
        .count_o   (cnt_pk[t]),
        .reload_o  (rld_pk[t]),
        .hit_o     (hit[t])
      );
    end
  endgenerate

  qdt_irq_ctrl #(
    .NUM_CH (NUM_CH)
  ) u_irq (
    .clk       (clk),
    .rst       (rst),
    .wr        (wr_irq),
    .ie_wdata  (bus_wdata[NUM_CH-1:0]),
    .clr_wdata (bus_wdata[PEND_LSB +: NUM_CH]),
    .hit       (hit),
    .ie_o      (ie),
    .pend_o    (pend),
    .irq_o     (irq)
  );

  // Read mux, registered below
  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if (word == WORD_W'(CTRL_WORD)) begin
        rd_next[CTL_W-1:0]         = ctl_q;
        rd_next[SRC_LSB +: NUM_CH] = src_q;
      end
      if (word == WORD_W'(IRQ_WORD)) begin
        rd_next[NUM_CH-1:0]         = ie;
        rd_next[PEND_LSB +: NUM_CH] = pend;
      end
      for (int t = 0; t < NUM_CH; t++) begin
        if (word == WORD_W'(RELOAD_WORD + t)) rd_next = rld_pk[t];
        if (word == WORD_W'(COUNT_WORD + t))  rd_next = cnt_pk[t];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/qdt_checker.sv
module qdt_checker #(
  parameter int NUM_CH    = 4,
  parameter int NARROW_CH = 2,
  parameter int NARROW_W  = 24,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [2*NUM_CH-1:0]           ctl_q,
  input logic [NUM_CH-1:0][DATA_W-1:0] cnt_pk,
  input logic [NUM_CH-1:0][DATA_W-1:0] rld_pk,
  input logic [NUM_CH-1:0]             pend,
  input logic [NUM_CH-1:0]             ie,
  input logic                          irq
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pend == '0 && !irq && ctl_q == '0));

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(pend & ie))));

  generate
    for (genvar t = 0; t < NUM_CH; t++) begin : g_chk
      logic cnt_wr;
      assign cnt_wr = bus_wr && (bus_addr == ADDR_W'(32 + 4*t));

      // R3
      dec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[2*t] && !cnt_wr && cnt_pk[t] != '0)
          |=> (cnt_pk[t] == $past(cnt_pk[t]) - DATA_W'(1)));

      // R3
      hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q[2*t] && !cnt_wr) |=> $stable(cnt_pk[t]));

      // R4
      pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[2*t] && !cnt_wr && cnt_pk[t] == DATA_W'(1)) |=> pend[t]);

      // R5
      reload_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[2*t] && ctl_q[2*t+1] && !cnt_wr && cnt_pk[t] == '0)
          |=> (cnt_pk[t] == $past(rld_pk[t])));

      // R6
      oneshot_park_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q[2*t] && !ctl_q[2*t+1] && !cnt_wr && cnt_pk[t] == '0)
          |=> (cnt_pk[t] == '0));

      if (t < NARROW_CH) begin : g_narrow
        // R10
        narrow_top_chk: assert property (@(posedge clk) disable iff (rst)
          (cnt_pk[t][DATA_W-1:NARROW_W] == '0 && rld_pk[t][DATA_W-1:NARROW_W] == '0));
      end
    end
  endgenerate
endmodule

bind quad_dtimer qdt_checker #(
  .NUM_CH    (NUM_CH),
  .NARROW_CH (NARROW_CH),
  .NARROW_W  (NARROW_W),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W)
) u_qdt_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .ctl_q    (ctl_q),
  .cnt_pk   (cnt_pk),
  .rld_pk   (rld_pk),
  .pend     (pend),
  .ie       (ie),
  .irq      (irq)
);

// File: tb/test_quad_dtimer.sv
module test_quad_dtimer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit armed = 1'b0;

  quad_dtimer i_quad_dtimer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt [4];
  logic [31:0] m_rld [4];
  logic [31:0] nc    [4];
  logic [7:0]  m_enmode;
  logic [3:0]  m_src, m_ie, m_pend, hits;
  logic [31:0] e_rdata;
  logic        e_irq;
  int          w;

  function automatic logic [31:0] lane_mask(int t);
    return (t < 2) ? 32'h00FF_FFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] model_read(logic [5:0] a);
    int wi = int'(a[5:2]);
    if (a[1:0] != 2'b00) return 32'h0;
    if (wi == 0) return {20'h0, m_src, m_enmode};
    if (wi == 1) return {24'h0, m_pend, m_ie};
    if (wi >= 4 && wi < 8)  return m_rld[wi-4];
    if (wi >= 8 && wi < 12) return m_cnt[wi-8];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      for (int t = 0; t < 4; t++) begin m_cnt[t] = '0; m_rld[t] = '0; end
      m_enmode = '0; m_src = '0; m_ie = '0; m_pend = '0;
      e_rdata = '0; e_irq = 1'b0;
    end else begin
      w = (bus_addr[1:0] == 2'b00) ? int'(bus_addr[5:2]) : 99;
      e_rdata = model_read(bus_addr);
      e_irq   = |(m_pend & m_ie);
      hits = '0;
      for (int t = 0; t < 4; t++) begin
        if (bus_wr && w == 8 + t) nc[t] = bus_wdata & lane_mask(t);
        else if (m_enmode[2*t] && m_cnt[t] != 0) begin
          nc[t] = m_cnt[t] - 1;
          if (m_cnt[t] == 1) hits[t] = 1'b1;
        end else if (m_enmode[2*t] && m_enmode[2*t+1]) nc[t] = m_rld[t];
        else nc[t] = m_cnt[t];
      end
      for (int t = 0; t < 4; t++) begin
        if (bus_wr && w == 4 + t) m_rld[t] = bus_wdata & lane_mask(t);
        m_cnt[t] = nc[t];
      end
      if (bus_wr && w == 0) begin m_enmode = bus_wdata[7:0]; m_src = bus_wdata[11:8]; end
      if (bus_wr && w == 1) begin m_pend = m_pend & ~bus_wdata[7:4]; m_ie = bus_wdata[3:0]; end
      m_pend = m_pend | hits;
    end
  end

  // Every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (armed) begin
      checks += 2;
      if (bus_rdata !== e_rdata) begin
        errors++;
        $display("FAIL %s R11 rdata addr=%h actual=%h expected=%h", phase, bus_addr, bus_rdata, e_rdata);
      end
      if (irq !== e_irq) begin
        errors++;
        $display("FAIL %s R9 irq actual=%b expected=%b", phase, irq, e_irq);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [5:0] a);
    @(negedge clk); bus_wr = 1'b0; bus_addr = a;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); bus_wr = 1'b0; end
  endtask

  task automatic expect_rd(input logic [5:0] a, input logic [31:0] exp, input string req);
    rd(a);
    @(negedge clk);
    checks++;
    if (bus_rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic expect_irq(input logic exp, input string req);
    @(negedge clk);
    checks++;
    if (irq !== exp) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", req, irq, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    idle(3);
    @(negedge clk); rst = 1'b0;

    phase = "R1";
    expect_rd(6'h00, 32'h0, "R1 ctrl");
    expect_rd(6'h04, 32'h0, "R1 irq word");
    expect_rd(6'h2C, 32'h0, "R1 count3");
    expect_irq(1'b0, "R1");

    phase = "R2";
    wr(6'h00, 32'h0000_0F00);
    expect_rd(6'h00, 32'h0000_0F00, "R2 source flags");
    wr(6'h00, 32'hFFFF_FFFF);
    expect_rd(6'h00, 32'h0000_0FFF, "R2 unused bits");
    wr(6'h00, 32'h0);

    phase = "R10";
    wr(6'h10, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    expect_rd(6'h10, 32'h00FF_FFFF, "R10 reload0");
    expect_rd(6'h20, 32'h00FF_FFFF, "R10 count0");
    wr(6'h18, 32'hFFFF_FFFF);
    expect_rd(6'h18, 32'hFFFF_FFFF, "R10 wide reload2");

    phase = "R3";
    wr(6'h28, 32'hFFFF_FFFF);
    wr(6'h00, 32'h0000_0030);
    rd(6'h28); idle(6);
    wr(6'h00, 32'h0);
    rd(6'h28); idle(1);
    @(negedge clk); snap = bus_rdata;
    idle(3);
    checks++;
    if (bus_rdata !== snap) begin
      errors++;
      $display("FAIL R3 hold actual=%h expected=%h", bus_rdata, snap);
    end

    phase = "R5";
    wr(6'h04, 32'h0000_0008);
    wr(6'h1C, 32'd4);
    wr(6'h2C, 32'd4);
    wr(6'h00, 32'h0000_00C0);
    rd(6'h2C); idle(9);
    phase = "R4";
    rd(6'h04); idle(12);
    expect_irq(1'b1, "R9 set");

    phase = "R8";
    wr(6'h04, 32'h0000_0008);
    wr(6'h00, 32'h0);
    expect_rd(6'h04, 32'h0000_0088, "R8 zero keeps");
    snap = bus_rdata;
    wr(6'h04, snap);
    expect_rd(6'h04, 32'h0000_0008, "R8 clear");
    expect_irq(1'b0, "R9 clear");

    phase = "R6";
    wr(6'h24, 32'd3);
    wr(6'h14, 32'd7);
    wr(6'h00, 32'h0000_0004);
    rd(6'h24); idle(10);
    expect_rd(6'h24, 32'h0, "R6 parked");
    expect_rd(6'h04, 32'h0000_0028, "R4 pending1");

    phase = "R7";
    wr(6'h00, 32'h0000_0030);
    wr(6'h28, 32'd100);
    expect_rd(6'h28, 32'd100, "R7 write wins");
    idle(4);
    wr(6'h00, 32'h0);

    phase = "R11";
    expect_rd(6'h3C, 32'h0, "R11 unmapped");
    expect_rd(6'h05, 32'h0, "R11 misaligned");

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule